// File: doc/BRIEF.md
# Single-Channel Copy/Fill Word DMA

This block is one DMA channel that moves 32-bit words from one memory region to another, or fills a region with a constant word. Software sets up the channel through a small synchronous register port: low source and destination addresses, a shared register holding the upper address byte of each, a word count, a fill pattern and a control word. It then sets the enable bit to start the transfer. A status register reports whether the channel is still busy.

On the memory side the channel acts as a word-wide master with separate read and write request/ready handshakes. In copy mode it alternates one read and one write per word. In fill mode it issues only writes. Addresses are 40 bits wide and step by 4 after each word. When the last word has been written, a run-once transfer goes idle and, if asked, raises a one-cycle completion pulse. A transfer without run-once starts again from the programmed addresses until software stops it.

Top module: `wordmove_dma`

## Requirements
- R1: After reset, every register reads 0, busy is clear, no memory request is raised and `done` is low.
- R2: Register offsets and readback: 0x00 control (bits 30:0 read back as written, bit 31 reads the busy state), 0x04 status (bit 31 busy, other bits 0), 0x0C source low word, 0x10 destination low word, 0x14 upper address bytes (source in bits 7:0, destination in bits 23:16, other bits read 0), 0x20 word count (low CNT_W bits kept), 0x34 fill pattern, 0x38 access field (bits 1:0). Any other offset reads 0.
- R3: A control write with bit 31 set while idle starts a transfer only if the mode field in bits 23:21 is 4 (copy) or 6 (fill). Busy then reads 1 from the next cycle. Any other mode value stores the fields but does not start, and bit 31 reads 0.
- R4: In copy mode each word raises `mem_rd_req` at the current source address and holds it with a stable address until `mem_rd_rdy`. The captured word is then offered on `mem_wr_req` at the current destination address until `mem_wr_rdy`.
- R5: In fill mode no read is requested, and every write carries the pattern register value.
- R6: The 40-bit addresses are formed as {upper byte, low word}. They advance by 4 after each word and wrap modulo 2^40.
- R7: A word count of N moves N+1 words, so a count of 0 moves exactly one word.
- R8: With run-once (control bit 27) set, busy and the enable bit clear in the cycle after the last write handshake. `done` pulses for that one cycle only if control bit 15 is set.
- R9: With run-once clear, the channel restarts from the programmed addresses after the last word and stays busy. It pulses `done` at the end of every pass when bit 15 is set.
- R10: A control write with bit 31 clear while busy stops the channel. Requests drop in the next cycle, busy clears and no `done` pulse is raised.
- R11: While busy, writes to 0x0C, 0x10, 0x14, 0x20 and 0x34 are ignored, and so is a control write with bit 31 set.
- R12: The access field at 0x38 can be written at any time, including while busy, and reads back its two stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | 40 | Memory read byte address |
| mem_rd_rdy | input | 1 | Read accepted; data valid this cycle |
| mem_rd_data | input | 32 | Memory read data |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_addr | output | 40 | Memory write byte address |
| mem_wr_data | output | 32 | Memory write data |
| mem_wr_rdy | input | 1 | Write accepted this cycle |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
A corrupted word counter or address register does not stay hidden. It shows on the next memory request as a wrong address, an extra or missing write, or a `done` pulse in the wrong cycle, and the reference model compares these on every clock. A wrong phase, such as a read issued in fill mode or a request that survives a stop, shows at the request pins one cycle after the handshake that caused it. Register state that a busy transfer should have protected is read back through the register port right after the write attempt.

// File: rtl/wordmove_dma.sv
module wordmove_dma #(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_rd_req,
  output logic [39:0] mem_rd_addr,
  input  logic        mem_rd_rdy,
  input  logic [31:0] mem_rd_data,
  output logic        mem_wr_req,
  output logic [39:0] mem_wr_addr,
  output logic [31:0] mem_wr_data,
  input  logic        mem_wr_rdy,
  output logic        done
);
  localparam logic [2:0] M_COPY = 3'd4;
  localparam logic [2:0] M_FILL = 3'd6;
  localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_SRC = 8'h0C, A_DST = 8'h10;
  localparam logic [7:0] A_HI = 8'h14, A_CNT = 8'h20, A_PAT = 8'h34, A_ACC = 8'h38;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t              st;
  logic [30:0]      ctrl_q;
  logic [31:0]      src_lo, dst_lo, pat_q, buf_q;
  logic [7:0]       src_hi, dst_hi;
  logic [CNT_W-1:0] cnt_q, left_q;
  logic [1:0]       acc_q;
  logic [39:0]      cur_src, cur_dst;
  logic             done_q;

  logic busy, ctrl_wr, start, stop, fill, rd_hs, wr_hs, last;
  logic [2:0] new_mode;

  assign busy     = (st != S_IDLE);
  assign ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
  assign new_mode = reg_wdata[23:21];
  assign start    = ctrl_wr && !busy && reg_wdata[31] && (new_mode == M_COPY || new_mode == M_FILL);
  assign stop     = ctrl_wr && busy && !reg_wdata[31];
  assign fill     = (ctrl_q[23:21] == M_FILL);
  assign rd_hs    = (st == S_RD) && mem_rd_rdy;
  assign wr_hs    = (st == S_WR) && mem_wr_rdy;
  assign last     = (left_q == '0);

  assign mem_rd_req  = (st == S_RD);
  assign mem_rd_addr = cur_src;
  assign mem_wr_req  = (st == S_WR);
  assign mem_wr_addr = cur_dst;
  assign mem_wr_data = fill ? pat_q : buf_q;
  assign done        = done_q;

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {busy, ctrl_q};
      A_STAT:  reg_rdata = {busy, 31'd0};
      A_SRC:   reg_rdata = src_lo;
      A_DST:   reg_rdata = dst_lo;
      A_HI:    reg_rdata = {8'd0, dst_hi, 8'd0, src_hi};
      A_CNT:   reg_rdata = 32'(cnt_q);
      A_PAT:   reg_rdata = pat_q;
      A_ACC:   reg_rdata = {30'd0, acc_q};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ctrl_q  <= '0;
      src_lo  <= '0;
      dst_lo  <= '0;
      src_hi  <= '0;
      dst_hi  <= '0;
      cnt_q   <= '0;
      pat_q   <= '0;
      acc_q   <= '0;
      buf_q   <= '0;
      left_q  <= '0;
      cur_src <= '0;
      cur_dst <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (reg_wr && !busy) begin
        case (reg_addr)
          A_SRC: src_lo <= reg_wdata;
          A_DST: dst_lo <= reg_wdata;
          A_HI: begin
            src_hi <= reg_wdata[7:0];
            dst_hi <= reg_wdata[23:16];
          end
          A_CNT: cnt_q <= reg_wdata[CNT_W-1:0];
          A_PAT: pat_q <= reg_wdata;
          default: ;
        endcase
      end
      if (reg_wr && reg_addr == A_ACC) acc_q <= reg_wdata[1:0];
      if (ctrl_wr && !(busy && reg_wdata[31])) ctrl_q <= reg_wdata[30:0];

      if (start) begin
        cur_src <= {src_hi, src_lo};
        cur_dst <= {dst_hi, dst_lo};
        left_q  <= cnt_q;
        st      <= (new_mode == M_FILL) ? S_WR : S_RD;
      end else if (stop) begin
        st <= S_IDLE;
      end else if (rd_hs) begin
        buf_q <= mem_rd_data;
        st    <= S_WR;
      end else if (wr_hs) begin
        if (last) begin
          done_q <= ctrl_q[15];
          if (ctrl_q[27]) begin
            st <= S_IDLE;
          end else begin
            cur_src <= {src_hi, src_lo};
            cur_dst <= {dst_hi, dst_lo};
            left_q  <= cnt_q;
            st      <= fill ? S_WR : S_RD;
          end
        end else begin
          cur_src <= cur_src + 40'd4;
          cur_dst <= cur_dst + 40'd4;
          left_q  <= left_q - CNT_W'(1);
          st      <= fill ? S_WR : S_RD;
        end
      end
    end
  end

  a_r4_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_rdy && !stop) |=> (mem_rd_req && $stable(mem_rd_addr)));

  a_r5_fill_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fill) |-> !mem_rd_req);

  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && mem_wr_rdy && !last && !stop) |=> (mem_wr_addr == $past(mem_wr_addr) + 40'd4));

  a_r8_runonce_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hs && last && ctrl_q[27]) |=> !busy);

  a_r10_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!mem_rd_req && !mem_wr_req && !done));

  a_r11_src_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == A_SRC) |=> $stable(src_lo));
endmodule

// File: tb/test_wordmove_dma.sv
module test_wordmove_dma;
  localparam int CNTW = 16;
  localparam int CMASK = (1 << CNTW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_rd_req, mem_wr_req, done;
  logic [39:0] mem_rd_addr, mem_wr_addr;
  logic        mem_rd_rdy = 1'b1, mem_wr_rdy = 1'b1;
  logic [31:0] mem_rd_data, mem_wr_data;

  int total = 0, bad = 0, cycles = 0;
  int nwr = 0, nrd = 0, ndone = 0;
  logic [39:0] last_wa;
  logic [31:0] last_wd;
  logic stall = 1'b0;
  logic [7:0] lfsr = 8'h5B;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  wordmove_dma #(.CNT_W(CNTW)) i_wordmove_dma (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_rdy(mem_rd_rdy),
    .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_rdy(mem_wr_rdy), .done(done));

  function automatic logic [31:0] memfn(input logic [39:0] a);
    return a[31:0] ^ {a[39:32], 24'h5A3C96};
  endfunction

  assign mem_rd_data = memfn(mem_rd_addr);

  // reference model
  logic [30:0] m_ctrl;
  logic [31:0] m_slo, m_dlo, m_pat, m_buf;
  logic [7:0]  m_shi, m_dhi;
  int          m_cnt, m_left, m_phase;
  logic [1:0]  m_acc;
  logic [39:0] m_s, m_d;
  logic        m_done;
  logic        mb, mstart, mstop, mfill;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic b;
    b = (m_phase != 0);
    case (a)
      8'h00: return {b, m_ctrl};
      8'h04: return {b, 31'd0};
      8'h0C: return m_slo;
      8'h10: return m_dlo;
      8'h14: return {8'd0, m_dhi, 8'd0, m_shi};
      8'h20: return 32'(m_cnt);
      8'h34: return m_pat;
      8'h38: return {30'd0, m_acc};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= '0; m_slo <= '0; m_dlo <= '0; m_pat <= '0; m_buf <= '0;
      m_shi <= '0; m_dhi <= '0; m_cnt <= 0; m_left <= 0; m_phase <= 0;
      m_acc <= '0; m_s <= '0; m_d <= '0; m_done <= 1'b0;
    end else begin
      mb = (m_phase != 0);
      mfill = (m_ctrl[23:21] == 3'd6);
      mstart = reg_wr && reg_addr == 8'h00 && !mb && reg_wdata[31] &&
               (reg_wdata[23:21] == 3'd4 || reg_wdata[23:21] == 3'd6);
      mstop = reg_wr && reg_addr == 8'h00 && mb && !reg_wdata[31];
      m_done <= 1'b0;
      if (reg_wr && !mb) begin
        if (reg_addr == 8'h0C) m_slo <= reg_wdata;
        if (reg_addr == 8'h10) m_dlo <= reg_wdata;
        if (reg_addr == 8'h14) begin m_shi <= reg_wdata[7:0]; m_dhi <= reg_wdata[23:16]; end
        if (reg_addr == 8'h20) m_cnt <= int'(reg_wdata) & CMASK;
        if (reg_addr == 8'h34) m_pat <= reg_wdata;
      end
      if (reg_wr && reg_addr == 8'h38) m_acc <= reg_wdata[1:0];
      if (reg_wr && reg_addr == 8'h00 && (!mb || !reg_wdata[31])) m_ctrl <= reg_wdata[30:0];
      if (mstart) begin
        m_s <= {m_shi, m_slo};
        m_d <= {m_dhi, m_dlo};
        m_left <= m_cnt;
        m_phase <= (reg_wdata[23:21] == 3'd6) ? 2 : 1;
      end else if (mstop) begin
        m_phase <= 0;
      end else if (m_phase == 1 && mem_rd_rdy) begin
        m_buf <= memfn(m_s);
        m_phase <= 2;
      end else if (m_phase == 2 && mem_wr_rdy) begin
        if (m_left == 0) begin
          m_done <= m_ctrl[15];
          if (m_ctrl[27]) m_phase <= 0;
          else begin
            m_s <= {m_shi, m_slo};
            m_d <= {m_dhi, m_dlo};
            m_left <= m_cnt;
            m_phase <= mfill ? 2 : 1;
          end
        end else begin
          m_s <= m_s + 40'd4;
          m_d <= m_d + 40'd4;
          m_left <= m_left - 1;
          m_phase <= mfill ? 2 : 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, after inputs for the next edge are set
  always begin
    @(posedge clk);
    #15;
    if (rst_n && !finished) begin
      chk("R4 rd_req", 64'(mem_rd_req), 64'(m_phase == 1));
      if (m_phase == 1) chk("R6 rd_addr", 64'(mem_rd_addr), 64'(m_s));
      chk("R5 wr_req", 64'(mem_wr_req), 64'(m_phase == 2));
      if (m_phase == 2) begin
        chk("R6 wr_addr", 64'(mem_wr_addr), 64'(m_d));
        chk("R5 wr_data", 64'(mem_wr_data),
            64'((m_ctrl[23:21] == 3'd6) ? m_pat : m_buf));
      end
      chk("R8 done", 64'(done), 64'(m_done));
      chk("R2 rdata", 64'(reg_rdata), 64'(m_read(reg_addr)));
      if (mem_wr_req && mem_wr_rdy) begin nwr++; last_wa = mem_wr_addr; last_wd = mem_wr_data; end
      if (mem_rd_req && mem_rd_rdy) nrd++;
      if (done) ndone++;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_rd_rdy = stall ? lfsr[0] : 1'b1;
      mem_wr_rdy = stall ? lfsr[2] : 1'b1;
    end
  end

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rchk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    reg_addr = 8'h04;
    while (n < 3000) begin
      @(negedge clk);
      reg_addr = 8'h04;
      #1;
      if (!reg_rdata[31]) break;
      n++;
    end
    chk("R8 idle reached", 64'(reg_rdata[31]), 64'd0);
  endtask

  task automatic finish_up();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++; bad++;
        $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
        finish_up();
      end
    end
  end

  initial begin
    int w0, d0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rchk(8'h00, 32'd0, "R1 ctrl");
    rchk(8'h04, 32'd0, "R1 status");
    rchk(8'h20, 32'd0, "R1 count");
    chk("R1 no read req", 64'(mem_rd_req), 64'd0);
    chk("R1 no write req", 64'(mem_wr_req), 64'd0);
    chk("R1 done low", 64'(done), 64'd0);

    // R2 register map
    wreg(8'h0C, 32'h1000_0000);
    wreg(8'h10, 32'h2000_0000);
    wreg(8'h14, 32'hAB34_CD12);
    wreg(8'h20, 32'h0001_2345);
    wreg(8'h34, 32'hDEAD_BEEF);
    wreg(8'h38, 32'hFFFF_FFFF);
    wreg(8'h04, 32'hFFFF_FFFF);
    rchk(8'h0C, 32'h1000_0000, "R2 src low");
    rchk(8'h10, 32'h2000_0000, "R2 dst low");
    rchk(8'h14, 32'h0034_0012, "R2 upper bytes");
    rchk(8'h20, 32'h0000_2345, "R2 count width");
    rchk(8'h34, 32'hDEAD_BEEF, "R2 pattern");
    rchk(8'h38, 32'h0000_0003, "R12 access field");
    rchk(8'h04, 32'h0000_0000, "R2 status read-only");
    rchk(8'h40, 32'h0000_0000, "R2 unmapped");

    // R3 invalid mode does not start
    wreg(8'h00, 32'h88A0_0000);
    rchk(8'h04, 32'd0, "R3 bad mode idle");
    rchk(8'h00, 32'h08A0_0000, "R3 bad mode fields");

    // R4 R7 R8 copy of four words with stalls
    wreg(8'h20, 32'd3);
    stall = 1'b1;
    w0 = nwr; d0 = ndone; r0 = nrd;
    wreg(8'h00, 32'h8880_8400);
    rchk(8'h04, 32'h8000_0000, "R3 busy after start");
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R7 copy words", 64'(nwr - w0), 64'd4);
    chk("R4 copy reads", 64'(nrd - r0), 64'd4);
    chk("R8 done once", 64'(ndone - d0), 64'd1);
    chk("R6 copy last addr", 64'(last_wa), 64'h34_2000_000C);
    chk("R4 copy last data", 64'(last_wd), 64'(memfn(40'h12_1000_000C)));
    rchk(8'h00, 32'h0880_8400, "R8 enable cleared");

    // R5 R6 fill with 40-bit wrap, no irq
    wreg(8'h10, 32'hFFFF_FFF8);
    wreg(8'h14, 32'h00FF_0000);
    wreg(8'h20, 32'd2);
    w0 = nwr; d0 = ndone; r0 = nrd;
    wreg(8'h00, 32'h88C0_0400);
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R7 fill words", 64'(nwr - w0), 64'd3);
    chk("R5 no reads in fill", 64'(nrd - r0), 64'd0);
    chk("R6 wrap to zero", 64'(last_wa), 64'h0);
    chk("R5 pattern data", 64'(last_wd), 64'hDEAD_BEEF);
    chk("R8 no done without irq", 64'(ndone - d0), 64'd0);

    // R7 count zero moves one word
    wreg(8'h20, 32'd0);
    w0 = nwr;
    wreg(8'h00, 32'h88C0_8000);
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R7 single word", 64'(nwr - w0), 64'd1);

    // R11 R12 R10 lock while busy, then stop
    wreg(8'h0C, 32'h3000_0000);
    wreg(8'h14, 32'h0001_0002);
    wreg(8'h20, 32'd9);
    wreg(8'h00, 32'h8880_8000);
    wreg(8'h0C, 32'h7777_0000);
    rchk(8'h0C, 32'h3000_0000, "R11 src locked");
    wreg(8'h20, 32'd1);
    rchk(8'h20, 32'd9, "R11 count locked");
    wreg(8'h00, 32'h80C0_0000);
    rchk(8'h00, 32'h8880_8000, "R11 ctrl locked");
    wreg(8'h38, 32'd1);
    rchk(8'h38, 32'd1, "R12 access while busy");
    rchk(8'h04, 32'h8000_0000, "R10 busy before stop");
    d0 = ndone;
    wreg(8'h00, 32'h0000_0000);
    #1;
    chk("R10 rd req dropped", 64'(mem_rd_req), 64'd0);
    chk("R10 wr req dropped", 64'(mem_wr_req), 64'd0);
    rchk(8'h04, 32'd0, "R10 idle after stop");
    repeat (3) @(negedge clk);
    chk("R10 no done on stop", 64'(ndone - d0), 64'd0);

    // R9 repeating fill
    stall = 1'b0;
    wreg(8'h20, 32'd1);
    d0 = ndone;
    wreg(8'h00, 32'h80C0_8000);
    begin
      int n;
      n = 0;
      while ((ndone - d0) < 3 && n < 200) begin @(negedge clk); n++; end
    end
    chk("R9 repeated passes", 64'((ndone - d0) >= 3), 64'd1);
    rchk(8'h04, 32'h8000_0000, "R9 still busy");
    wreg(8'h00, 32'h0000_0000);
    rchk(8'h04, 32'd0, "R10 repeat stopped");

    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule